// File: doc/BRIEF.md
# Multi-Listener Source Handshake

This block is the sending side of a three-line interlocked byte transfer over an 8-bit bus that several receivers share. It holds one byte on the bus and raises a data-valid strobe. Two combined status lines come back from the receivers: one that reads "not ready" and one that reads "not yet accepted". Each combined line is an OR of the per-receiver conditions, which models a wired-AND bus line. It stays asserted until the last receiver has released it. A small merge stage inside the block forms both combined lines from the per-receiver inputs, and a chain of synchronizer flops carries them into the clock domain.

On the local side the block raises a write request. The local host answers with a one-cycle write-complete pulse that carries the next byte. A new write starts as soon as every receiver has accepted the current byte. The block does not wait for the receivers to become ready again. The strobe rises only when both conditions hold: the write has completed and all receivers are ready. Whichever of the two arrives first decides which intermediate state the block passes through.

The states are WRITE, WAIT, STILL and VALID. WRITE means a byte is being requested and no receiver readiness has been seen. WAIT means the byte is loaded and the block is waiting for readiness. STILL means readiness has been seen while the write is still pending. VALID means the strobe is high. The transitions are:
- WRITE→WAIT on write-complete without readiness.
- WRITE→STILL on readiness without write-complete.
- WRITE→VALID on both in the same cycle.
- WAIT→VALID on readiness.
- STILL→VALID on write-complete.
- VALID→WRITE on all-accepted.

Top module: `talker_hs`

## Requirements
- R1: During reset and right after it, the strobe `dav` is 0, `wr_req` is 1 (state WRITE) and `bus_data` is 0.
- R2: `nrfd_line` is 1 whenever at least one bit of `lst_rdy` is 0, and the strobe cannot rise while it is 1.
- R3: `ndac_line` is 1 whenever at least one bit of `lst_acc` is 0, and the strobe stays high while it is 1.
- R4: A write-complete pulse in WRITE without readiness leads to WAIT: `wr_req` and `dav` are both 0 in the following cycle. The strobe rises in the cycle after the synchronized readiness reaches the state machine.
- R5: Readiness seen in WRITE without write-complete leads to STILL: `wr_req` stays 1 and `dav` stays 0. `dav` becomes 1 on the clock edge that samples the write-complete pulse.
- R6: When write-complete and synchronized readiness arrive on the same edge in WRITE, the block goes directly to VALID on that edge.
- R7: `bus_data` equals the byte that came with the accepted write-complete pulse. It does not change while `dav` is 1.
- R8: When the synchronized all-accepted condition is seen in VALID, `dav` falls and `wr_req` rises on the next edge.
- R9: A write-complete pulse in WAIT or VALID is ignored: `bus_data` is unchanged.
- R10: Changes on `lst_rdy` and `lst_acc` reach the state machine through SYNC_STAGES register stages (default 2). With the default, the strobe rises on the third edge after the last receiver becomes ready, and falls on the third edge after the last receiver accepts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lst_rdy | input | N_LISTEN | Per-receiver ready for data (1 = ready) |
| lst_acc | input | N_LISTEN | Per-receiver data accepted (1 = accepted) |
| wr_done | input | 1 | One-cycle write-complete pulse from the local host |
| wr_data | input | DATA_W | Byte that comes with `wr_done` |
| wr_req | output | 1 | Request to the host to write the next byte |
| dav | output | 1 | Data-valid strobe to the receivers |
| bus_data | output | DATA_W | Byte driven on the bus |
| nrfd_line | output | 1 | Combined not-ready line (1 while any receiver is not ready) |
| ndac_line | output | 1 | Combined not-accepted line (1 while any receiver has not accepted) |

## Verification
The combined lines are combinational, so the bench reads them in the same cycle as it drives the receiver inputs. Receiver-side inputs pass through two synchronizer flops and then the state register. The bench therefore drives them at a falling edge and expects the strobe to be unchanged two falling edges later and changed at the third. A write-complete pulse acts on the very next rising edge, so its effect is sampled one falling edge after it is driven. The bench sweeps every partial mask of three receivers, with a settling time of three cycles per mask. It runs each of the three arrival orders of readiness and write-complete with several data bytes.

// File: rtl/talker_hs_pkg.sv
package talker_hs_pkg;
    typedef enum logic [1:0] {
        TK_WRITE = 2'd0,
        TK_WAIT  = 2'd1,
        TK_STILL = 2'd2,
        TK_VALID = 2'd3
    } tk_state_e;
endpackage

// File: rtl/tk_listener_merge.sv
module tk_listener_merge #(
    parameter int N_LISTEN = 3
) (
    input  logic [N_LISTEN-1:0] lst_rdy,
    input  logic [N_LISTEN-1:0] lst_acc,
    output logic                nrfd_line,
    output logic                ndac_line
);
    // Each receiver holds its line asserted until it releases; the bus
    // behaves as a wired-AND of releases, i.e. an OR of the holds.
    logic [N_LISTEN:0] hold_rdy;
    logic [N_LISTEN:0] hold_acc;

    assign hold_rdy[0] = 1'b0;
    assign hold_acc[0] = 1'b0;

    for (genvar i = 0; i < N_LISTEN; i++) begin : g_merge
        assign hold_rdy[i+1] = hold_rdy[i] | ~lst_rdy[i];
        assign hold_acc[i+1] = hold_acc[i] | ~lst_acc[i];
    end

    assign nrfd_line = hold_rdy[N_LISTEN];
    assign ndac_line = hold_acc[N_LISTEN];
endmodule

// File: rtl/tk_sync.sv
module tk_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

    // R10: first stage captures the bus value of the previous cycle
    p_first_stage_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chain[0] == $past(d));
endmodule

// File: rtl/tk_fsm.sv
module tk_fsm
    import talker_hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rfd_s,
    input  logic              dac_s,
    input  logic              wr_done,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_req,
    output logic              dav,
    output logic [DATA_W-1:0] bus_data
);
    tk_state_e         state, state_nx;
    logic [DATA_W-1:0] data_q;
    logic              load;

    always_comb begin
        state_nx = state;
        unique case (state)
            TK_WRITE: begin
                if (wr_done && rfd_s)  state_nx = TK_VALID;
                else if (wr_done)      state_nx = TK_WAIT;
                else if (rfd_s)        state_nx = TK_STILL;
            end
            TK_WAIT:  if (rfd_s)   state_nx = TK_VALID;
            TK_STILL: if (wr_done) state_nx = TK_VALID;
            TK_VALID: if (dac_s)   state_nx = TK_WRITE;
            default:  state_nx = TK_WRITE;
        endcase
    end

    assign load = wr_done && (state == TK_WRITE || state == TK_STILL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= TK_WRITE;
            data_q <= '0;
        end else begin
            state <= state_nx;
            if (load) data_q <= wr_data;
        end
    end

    always_comb begin
        wr_req   = 1'b0;
        dav      = 1'b0;
        unique case (state)
            TK_WRITE, TK_STILL: wr_req = 1'b1;
            TK_VALID:           dav    = 1'b1;
            default:            ;
        endcase
        bus_data = data_q;
    end

    // R4: waiting with a loaded byte keeps the strobe low until readiness
    p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TK_WAIT && !rfd_s) |=> (state == TK_WAIT && !dav));
    // R5: still writing keeps requesting until the write completes
    p_still_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TK_STILL && !wr_done) |=> (wr_req && !dav));
    // R6: direct entry from WRITE needs readiness in the same cycle
    p_direct_needs_rfd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TK_WRITE && wr_done && !rfd_s) |=> !dav);
    // R7: bus byte stable while the strobe stays high
    p_data_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dav && $past(dav)) |-> $stable(bus_data));
    // R8: all-accepted withdraws the strobe and starts the next write
    p_dac_drops_dav_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dav && dac_s) |=> (!dav && wr_req));
endmodule

// File: rtl/talker_hs.sv
module talker_hs
    import talker_hs_pkg::*;
#(
    parameter int N_LISTEN    = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_LISTEN-1:0] lst_rdy,
    input  logic [N_LISTEN-1:0] lst_acc,
    input  logic                wr_done,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                wr_req,
    output logic                dav,
    output logic [DATA_W-1:0]   bus_data,
    output logic                nrfd_line,
    output logic                ndac_line
);
    localparam int LINES = 2;

    logic [LINES-1:0] lines_raw;
    logic [LINES-1:0] lines_s;

    tk_listener_merge #(.N_LISTEN(N_LISTEN)) u_merge (
        .lst_rdy   (lst_rdy),
        .lst_acc   (lst_acc),
        .nrfd_line (nrfd_line),
        .ndac_line (ndac_line)
    );

    assign lines_raw = {ndac_line, nrfd_line};

    tk_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lines_raw),
        .q     (lines_s)
    );

    tk_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rfd_s    (~lines_s[0]),
        .dac_s    (~lines_s[1]),
        .wr_done  (wr_done),
        .wr_data  (wr_data),
        .wr_req   (wr_req),
        .dav      (dav),
        .bus_data (bus_data)
    );
endmodule

// File: tb/talker_hs_bench.sv
module talker_hs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 3;
    localparam int FULL       = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] rdy, acc;
    logic         wr_done;
    logic [7:0]   wr_data;
    logic         wr_req, dav, nrfd_line, ndac_line;
    logic [7:0]   bus_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    talker_hs #(.N_LISTEN(N), .DATA_W(8), .SYNC_STAGES(2)) u_talker_hs (
        .clk(clk), .rst_n(rst_n), .lst_rdy(rdy), .lst_acc(acc),
        .wr_done(wr_done), .wr_data(wr_data), .wr_req(wr_req), .dav(dav),
        .bus_data(bus_data), .nrfd_line(nrfd_line), .ndac_line(ndac_line)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic pulse_write(input logic [7:0] d);
        wr_data = d; wr_done = 1'b1;
        tick(1);
        wr_done = 1'b0;
    endtask

    // R4 order: byte first, readiness later, swept over partial masks (R2)
    task automatic byte_wait_first(input logic [7:0] d);
        pulse_write(d);
        chk(dav == 1'b0,    "R4 dav in WAIT", dav, 0);
        chk(wr_req == 1'b0, "R4 wr_req in WAIT", wr_req, 0);
        pulse_write(~d);
        chk(bus_data == d, "R9 write ignored in WAIT", bus_data, d);
        for (int m = 0; m < FULL; m++) begin
            rdy = m[N-1:0];
            tick(3);
            chk(nrfd_line == 1'b1, "R2 combined not-ready", nrfd_line, 1);
            chk(dav == 1'b0, "R2 dav with partial ready", dav, 0);
        end
        rdy = FULL[N-1:0];
        tick(1);
        chk(nrfd_line == 1'b0, "R2 combined released", nrfd_line, 0);
        tick(1);
        chk(dav == 1'b0, "R10 dav before sync delay", dav, 0);
        tick(1);
        chk(dav == 1'b1, "R4 dav after readiness", dav, 1);
        chk(bus_data == d, "R7 bus byte", bus_data, d);
    endtask

    // R5 order: readiness first, write later
    task automatic byte_rfd_first(input logic [7:0] d);
        rdy = FULL[N-1:0];
        tick(5);
        chk(dav == 1'b0,    "R5 dav in STILL", dav, 0);
        chk(wr_req == 1'b1, "R5 wr_req in STILL", wr_req, 1);
        pulse_write(d);
        chk(dav == 1'b1, "R5 dav after write", dav, 1);
        chk(bus_data == d, "R7 bus byte", bus_data, d);
    endtask

    // R6 order: both reach the state machine on the same edge
    task automatic byte_same(input logic [7:0] d);
        rdy = FULL[N-1:0];
        tick(2);
        chk(wr_req == 1'b1, "R6 still in WRITE", wr_req, 1);
        pulse_write(d);
        chk(dav == 1'b1, "R6 direct to VALID", dav, 1);
        chk(bus_data == d, "R7 bus byte", bus_data, d);
    endtask

    task automatic accept(input logic [7:0] d);
        rdy = '0;
        for (int m = 0; m < FULL; m++) begin
            acc = m[N-1:0];
            if (m == 1) pulse_write(~d);
            tick(3);
            chk(ndac_line == 1'b1, "R3 combined not-accepted", ndac_line, 1);
            chk(dav == 1'b1, "R3 dav with partial accept", dav, 1);
            chk(bus_data == d, "R7 R9 byte stable in VALID", bus_data, d);
        end
        acc = FULL[N-1:0];
        tick(1);
        chk(ndac_line == 1'b0, "R3 combined released", ndac_line, 0);
        tick(1);
        chk(dav == 1'b1, "R10 dav before sync delay", dav, 1);
        tick(1);
        chk(dav == 1'b0,    "R8 dav withdrawn", dav, 0);
        chk(wr_req == 1'b1, "R8 next write requested", wr_req, 1);
        acc = '0;
        tick(3);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rdy = '0; acc = '0; wr_done = 1'b0; wr_data = '0;
        tick(3);
        chk(dav == 1'b0,      "R1 dav reset", dav, 0);
        chk(wr_req == 1'b1,   "R1 wr_req reset", wr_req, 1);
        chk(bus_data == 8'h0, "R1 bus reset", bus_data, 0);
        rst_n = 1'b1;
        tick(2);
        chk(dav == 1'b0 && wr_req == 1'b1, "R1 after reset", dav, 0);
        for (int r = 0; r < 3; r++) begin
            logic [7:0] b;
            b = 8'h3C + 8'(r * 8'h51);
            byte_wait_first(b);
            accept(b);
            b = b ^ 8'hA5;
            byte_rfd_first(b);
            accept(b);
            b = b + 8'h17;
            byte_same(b);
            accept(b);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule